// File: doc/BRIEF.md
# Runahead Execution Controller

This block is the control core of an in-order pipeline that keeps executing past a blocking data-cache miss. It owns the architectural register file, where every register carries a poison (INV) bit, and a shadow copy of that file. A load that misses in normal mode copies the live registers into the shadow and switches the block into runahead mode. Instructions then keep flowing. Results that depend on missing data are marked INV instead of being computed. Loads whose addresses are known send prefetch requests to memory.

While in runahead, the block suppresses every effect that could corrupt state. Stores do not write the data cache, and fills that belong to runahead prefetches are not allowed into it. Loads with poisoned or colliding addresses are not issued. A branch with a poisoned predicate freezes fetch. Runahead ends in one of two ways, chosen by a static pin: when the original miss returns, or when the original miss has returned and no request is left in flight. On exit, the block spends one cycle restoring the shadow registers and clearing all INV bits. In that same cycle it redirects fetch to the load that missed and flushes the instructions in flight.

Operands are read combinationally by source index. The external ALU returns its result in the same cycle. Load and store addresses are taken directly from the first source register.

Top module: `runahead_ctrl`

## Requirements
- R1: After reset the block is in normal mode, every register reads zero with INV clear, the outstanding count is zero, and `fetch_stall`, `redirect_valid` and `ra_active` are low.
- R2: In normal mode, instruction classes are encoded on `in_op` as 0 ALU, 1 load, 2 store and 3 branch. An ALU op writes `in_alu_res` to its destination. A hitting load writes `in_ldata`. A store raises `dc_wr_en` with address = source 1 and data = source 2. A branch raises `br_en`. Register writes appear on the operand ports from the next cycle.
- R3: A load that misses in normal mode raises `mem_req_valid` with `mem_req_addr` equal to its address. In the same cycle it takes the checkpoint of the registers as they were before that instruction and marks its destination INV. `ra_active` is high from the next cycle.
- R4: In runahead, a missing load writes its destination with INV set. Any ALU op with an INV source writes an INV result, so poison spreads through dependence chains.
- R5: In runahead, a store never raises `dc_wr_en`. A returning fill raises `dc_fill_en` only when `resp_line` equals the line of the original miss. Outside runahead every fill raises `dc_fill_en`.
- R6: A load whose address register is INV never raises `mem_req_valid`.
- R7: In runahead, a missing load whose set index (address bits [IDX_W+LINE_OFF-1:LINE_OFF]) equals that of the original miss is not issued.
- R8: In runahead, a branch with an INV source does not raise `br_en`. `fetch_stall` is high from the next cycle until the restore cycle, where it is low.
- R9: A miss taken while already in runahead does not retake the checkpoint and does not change the redirect PC.
- R10: With `exit_drain` low, a fill of the original line in runahead ends runahead. During the following cycle, `redirect_valid` is high for exactly one cycle with `redirect_pc` equal to the PC of the missing load. In that cycle the checkpoint values are visible with every INV bit clear, and any instruction presented is ignored.
- R11: With `exit_drain` high, runahead ends only in the cycle in which the original line has returned (now or earlier in the episode) and the outstanding count falls to zero.
- R12: The outstanding count rises on each issued request and falls on each fill. In runahead, a missing load is issued only while the count is below 2^CNT_W - 2, which keeps one slot for the next normal-mode miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exit_drain | input | 1 | Exit policy: 0 leave on original fill, 1 leave when all requests are drained |
| in_valid | input | 1 | Instruction present this cycle |
| in_op | input | 2 | Instruction class: 0 ALU, 1 load, 2 store, 3 branch |
| in_pc | input | PCW | PC of the instruction |
| in_rd | input | log2(NREG) | Destination register |
| in_rs1 | input | log2(NREG) | Source 1 (address for memory ops) |
| in_rs2 | input | log2(NREG) | Source 2 (store data, second ALU/branch operand) |
| in_alu_res | input | DW | ALU result for an ALU op |
| in_dhit | input | 1 | Load hits in the data cache |
| in_ldata | input | DW | Load data on a hit |
| resp_valid | input | 1 | A memory fill returns this cycle |
| resp_line | input | DW-LINE_OFF | Line address of the returning fill |
| op_a | output | DW | Value of source 1 |
| op_a_inv | output | 1 | INV bit of source 1 |
| op_b | output | DW | Value of source 2 |
| op_b_inv | output | 1 | INV bit of source 2 |
| mem_req_valid | output | 1 | Issue a memory request |
| mem_req_addr | output | DW | Request address |
| dc_wr_en | output | 1 | Store write permitted into the data cache |
| dc_wr_addr | output | DW | Store address |
| dc_wr_data | output | DW | Store data |
| dc_fill_en | output | 1 | Returning fill may be written into the data cache |
| br_en | output | 1 | Branch may resolve |
| fetch_stall | output | 1 | Hold fetch |
| redirect_valid | output | 1 | Restore cycle: refetch and flush |
| redirect_pc | output | PCW | PC to refetch |
| ra_active | output | 1 | Runahead mode |

## Verification
Directed cases come first. They enter runahead on a miss and build a poison chain. Then they present a load with a poisoned address, a load that collides in the set index, a nested miss, a store and a poisoned branch. A design that issued the poisoned or colliding load would send garbage prefetches or evict the line it waits for. One that retook the checkpoint on the nested miss would restore partly speculative values, which shows up when every register is probed after the restore cycle.

A drain-policy case returns the original line before a prefetch. An early exit there drops `ra_active` one fill too soon, and a leaked prefetch fill shows as a raised `dc_fill_en`. A counter-limit case fills the outstanding count and checks that the seventh miss is held back.

Long random runs under both policies then compare every output with a cycle model every cycle.

// File: rtl/runahead_ctrl.sv
module runahead_ctrl #(
  parameter int DW       = 16,
  parameter int PCW      = 16,
  parameter int NREG     = 8,
  parameter int LINE_OFF = 2,
  parameter int IDX_W    = 3,
  parameter int CNT_W    = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     exit_drain,
  input  logic                     in_valid,
  input  logic [1:0]               in_op,
  input  logic [PCW-1:0]           in_pc,
  input  logic [$clog2(NREG)-1:0]  in_rd,
  input  logic [$clog2(NREG)-1:0]  in_rs1,
  input  logic [$clog2(NREG)-1:0]  in_rs2,
  input  logic [DW-1:0]            in_alu_res,
  input  logic                     in_dhit,
  input  logic [DW-1:0]            in_ldata,
  input  logic                     resp_valid,
  input  logic [DW-LINE_OFF-1:0]   resp_line,
  output logic [DW-1:0]            op_a,
  output logic                     op_a_inv,
  output logic [DW-1:0]            op_b,
  output logic                     op_b_inv,
  output logic                     mem_req_valid,
  output logic [DW-1:0]            mem_req_addr,
  output logic                     dc_wr_en,
  output logic [DW-1:0]            dc_wr_addr,
  output logic [DW-1:0]            dc_wr_data,
  output logic                     dc_fill_en,
  output logic                     br_en,
  output logic                     fetch_stall,
  output logic                     redirect_valid,
  output logic [PCW-1:0]           redirect_pc,
  output logic                     ra_active
);

  localparam int LW   = DW - LINE_OFF;
  localparam int CMAX = (1 << CNT_W) - 1;
  localparam int CLIM = CMAX - 1;
  localparam logic [1:0] OP_ALU = 2'd0, OP_LD = 2'd1, OP_ST = 2'd2, OP_BR = 2'd3;

  logic [DW-1:0]    rf_q [NREG];
  logic [DW-1:0]    ck_q [NREG];
  logic [NREG-1:0]  inv_q;
  logic             ra_q, rst_q, stall_q, ps_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PCW-1:0]   mpc_q;
  logic [LW-1:0]    mline_q;

  logic act, is_alu, is_ld, is_st, is_br;
  logic src_inv, ld_miss, collide, req, prim, ps_nxt, exit_ra, enter, we, winv;
  logic [CNT_W-1:0] cnt_nxt;
  logic [DW-1:0]    wdata;

  assign op_a     = rf_q[in_rs1];
  assign op_b     = rf_q[in_rs2];
  assign op_a_inv = inv_q[in_rs1];
  assign op_b_inv = inv_q[in_rs2];

  assign act    = in_valid & ~rst_q;
  assign is_alu = in_op == OP_ALU;
  assign is_ld  = in_op == OP_LD;
  assign is_st  = in_op == OP_ST;
  assign is_br  = in_op == OP_BR;

  assign src_inv = op_a_inv | (op_b_inv & (is_alu | is_br));
  assign ld_miss = act & is_ld & ~in_dhit & ~op_a_inv;
  assign collide = op_a[LINE_OFF +: IDX_W] == mline_q[IDX_W-1:0];
  assign req     = ld_miss & (~ra_q | (~collide & (cnt_q < CNT_W'(CLIM))));

  assign prim    = resp_valid & (resp_line == mline_q);
  assign cnt_nxt = cnt_q + {{(CNT_W-1){1'b0}}, req} - {{(CNT_W-1){1'b0}}, resp_valid};
  assign ps_nxt  = ps_q | (ra_q & prim);
  assign exit_ra = ra_q & (exit_drain ? (ps_nxt & (cnt_nxt == '0)) : prim);
  assign enter   = ~ra_q & ld_miss;

  assign we    = act & (is_alu | is_ld);
  assign wdata = is_alu ? in_alu_res : in_ldata;
  assign winv  = is_alu ? src_inv : (op_a_inv | ~in_dhit);

  assign mem_req_valid  = req;
  assign mem_req_addr   = op_a;
  assign dc_wr_en       = act & is_st & ~ra_q;
  assign dc_wr_addr     = op_a;
  assign dc_wr_data     = op_b;
  assign dc_fill_en     = resp_valid & (~ra_q | prim);
  assign br_en          = act & is_br & ~(ra_q & src_inv);
  assign fetch_stall    = stall_q;
  assign redirect_valid = rst_q;
  assign redirect_pc    = mpc_q;
  assign ra_active      = ra_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        rf_q[i] <= '0;
        ck_q[i] <= '0;
      end
      inv_q   <= '0;
      ra_q    <= 1'b0;
      rst_q   <= 1'b0;
      stall_q <= 1'b0;
      ps_q    <= 1'b0;
      cnt_q   <= '0;
      mpc_q   <= '0;
      mline_q <= '0;
    end else begin
      cnt_q <= cnt_nxt;
      rst_q <= exit_ra;
      if (exit_ra) begin
        for (int i = 0; i < NREG; i++) rf_q[i] <= ck_q[i];
        inv_q   <= '0;
        ra_q    <= 1'b0;
        stall_q <= 1'b0;
        ps_q    <= 1'b0;
      end else begin
        if (we) begin
          rf_q[in_rd]  <= wdata;
          inv_q[in_rd] <= winv;
        end
        stall_q <= stall_q | (ra_q & act & is_br & src_inv);
        if (enter) begin
          for (int i = 0; i < NREG; i++) ck_q[i] <= rf_q[i];
          ra_q    <= 1'b1;
          mpc_q   <= in_pc;
          mline_q <= op_a[DW-1:LINE_OFF];
          ps_q    <= 1'b0;
        end else begin
          ps_q <= ps_nxt;
        end
      end
    end
  end

  // R12
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_W'(CMAX)) |-> !(mem_req_valid && !resp_valid));

  // R3
  enter_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ra_q && !rst_q && mem_req_valid) |=> ra_q);

  // R6
  inv_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == OP_LD && inv_q[in_rs1]) |-> !mem_req_valid);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_stall && ra_active) |=> (fetch_stall || redirect_valid));

  // R9
  ckpt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_q && $past(ra_q)) |-> ($stable(mpc_q) && $stable(mline_q)));

  // R10
  redirect_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> (!redirect_valid && !ra_active));

  // R10
  restore_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> (inv_q == '0 && !fetch_stall));

  // R11
  drain_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ra_q) && $past(exit_drain)) |-> (cnt_q == '0));

endmodule

// File: tb/tb_runahead_ctrl.sv
`timescale 1ns/1ps
module tb_runahead_ctrl;
  logic clk = 1'b0, rst_n = 1'b0, exit_drain = 1'b0;
  logic in_valid = 1'b0, in_dhit = 1'b0, resp_valid = 1'b0;
  logic [1:0] in_op = '0;
  logic [15:0] in_pc = '0, in_alu_res = '0, in_ldata = '0;
  logic [2:0] in_rd = '0, in_rs1 = '0, in_rs2 = '0;
  logic [13:0] resp_line = '0;
  logic [15:0] op_a, op_b, mem_req_addr, dc_wr_addr, dc_wr_data, redirect_pc;
  logic op_a_inv, op_b_inv, mem_req_valid, dc_wr_en, dc_fill_en, br_en;
  logic fetch_stall, redirect_valid, ra_active;

  always #2.5 clk = ~clk;

  runahead_ctrl dut (.*);

  int n_chk = 0, n_bad = 0;
  logic [15:0] m_r [8];
  logic [15:0] m_c [8];
  logic [7:0]  m_i;
  logic m_ra, m_rst, m_st, m_ps;
  int m_cnt;
  logic [15:0] m_pc;
  logic [13:0] m_ml;
  logic [15:0] q [64];
  int qh = 0, qn = 0;

  task automatic chk(input string r, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h exp %h", r, got, exp);
    end
  endtask

  function automatic logic src_of(input logic [1:0] op, input logic ai, input logic bi);
    return (op == 2'd1 || op == 2'd2) ? ai : (ai | bi);
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 8; i++) begin m_r[i] = '0; m_c[i] = '0; end
    m_i = '0; m_ra = 0; m_rst = 0; m_st = 0; m_ps = 0; m_cnt = 0; m_pc = '0; m_ml = '0;
    qh = 0; qn = 0;
  endtask

  task automatic step(input logic v, input logic [1:0] op, input logic [15:0] pc,
                      input int rd, input int rs1, input int rs2, input logic [15:0] alu,
                      input logic dhit, input logic [15:0] ld, input logic rv_in);
    logic rv, act, ai, bi, src, ldm, col, e_req, e_wr, prim, e_fill, e_br, ps_n, ex, wi;
    logic [15:0] opa, opb, wd;
    int cnt_n;
    string lr;
    rv = rv_in && (qn > 0);
    in_valid = v; in_op = op; in_pc = pc; in_rd = 3'(rd); in_rs1 = 3'(rs1); in_rs2 = 3'(rs2);
    in_alu_res = alu; in_dhit = dhit; in_ldata = ld; resp_valid = rv;
    resp_line = rv ? q[qh % 64][15:2] : '0;
    #1;
    act = v && !m_rst;
    opa = m_r[rs1]; opb = m_r[rs2]; ai = m_i[rs1]; bi = m_i[rs2];
    src = src_of(op, ai, bi);
    ldm = act && op == 2'd1 && !dhit && !ai;
    col = opa[4:2] == m_ml[2:0];
    e_req = ldm && (!m_ra || (!col && m_cnt < 6));
    e_wr = act && op == 2'd2 && !m_ra;
    prim = rv && (resp_line == m_ml);
    e_fill = rv && (!m_ra || prim);
    e_br = act && op == 2'd3 && !(m_ra && src);
    chk("R2 op_a", op_a, opa);
    chk("R2 op_b", op_b, opb);
    chk("R4 op_a_inv", op_a_inv, ai);
    chk("R4 op_b_inv", op_b_inv, bi);
    lr = (act && op == 2'd1 && ai) ? "R6" : (m_ra && ldm && col) ? "R7" :
         (m_ra && ldm && m_cnt >= 6) ? "R12" : "R3";
    chk({lr, " mem_req_valid"}, mem_req_valid, e_req);
    if (e_req) chk("R3 mem_req_addr", mem_req_addr, opa);
    chk(m_ra ? "R5 dc_wr_en" : "R2 dc_wr_en", dc_wr_en, e_wr);
    if (e_wr) chk("R2 dc_wr_data", {dc_wr_addr, dc_wr_data}, {opa, opb});
    chk("R5 dc_fill_en", dc_fill_en, e_fill);
    chk("R8 br_en", br_en, e_br);
    chk("R8 fetch_stall", fetch_stall, m_st);
    chk("R10 redirect_valid", redirect_valid, m_rst);
    if (m_rst) chk("R10 redirect_pc", redirect_pc, m_pc);
    chk(exit_drain ? "R11 ra_active" : "R3 ra_active", ra_active, m_ra);
    cnt_n = m_cnt + int'(e_req) - int'(rv);
    ps_n = m_ps | (m_ra & prim);
    ex = m_ra && (exit_drain ? (ps_n && cnt_n == 0) : prim);
    if (e_req) begin q[(qh + qn) % 64] = opa; qn++; end
    if (rv) begin qh++; qn--; end
    if (ex) begin
      for (int i = 0; i < 8; i++) m_r[i] = m_c[i];
      m_i = '0; m_ra = 0; m_st = 0; m_ps = 0;
    end else begin
      m_st = m_st | (m_ra && act && op == 2'd3 && src);
      if (!m_ra && ldm) begin
        for (int i = 0; i < 8; i++) m_c[i] = m_r[i];
        m_ra = 1; m_pc = pc; m_ml = opa[15:2]; m_ps = 0;
      end else m_ps = ps_n;
      if (act && (op == 2'd0 || op == 2'd1)) begin
        wd = (op == 2'd0) ? alu : ld;
        wi = (op == 2'd0) ? src : (ai | !dhit);
        m_r[rd] = wd; m_i[rd] = wi;
      end
    end
    m_rst = ex; m_cnt = cnt_n;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic alu(input int rd, input logic [15:0] val);
    step(1, 2'd0, 16'h0, rd, 0, 0, val, 0, 0, 0);
  endtask
  task automatic idle(input logic rv);
    step(0, 2'd0, 16'h0, 0, 0, 0, 0, 1, 0, rv);
  endtask
  task automatic probe(input string r, input int idx, input logic [15:0] val, input logic inv);
    in_valid = 0; in_rs1 = 3'(idx); #1;
    chk(r, {op_a_inv, op_a}, {inv, val});
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired got running exp done");
    finish_run();
  end

  initial begin
    logic [15:0] snap [8];
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1; @(negedge clk);
    // R1 reset state
    for (int i = 0; i < 8; i++) probe("R1 reg", i, 16'h0, 1'b0);
    chk("R1 outputs", {ra_active, fetch_stall, redirect_valid}, 3'b000);
    // R2 normal mode
    alu(1, 16'h0100); alu(2, 16'h0200); alu(5, 16'h0055);
    step(1, 2'd1, 16'h10, 3, 1, 0, 0, 1, 16'h1234, 0);
    probe("R2 load hit", 3, 16'h1234, 0);
    step(1, 2'd2, 16'h14, 0, 2, 3, 0, 0, 0, 0);
    step(1, 2'd3, 16'h18, 0, 1, 2, 0, 0, 0, 0);
    for (int i = 0; i < 8; i++) snap[i] = m_r[i];
    // R3 entry
    step(1, 2'd1, 16'h40, 4, 1, 0, 0, 0, 0, 0);
    chk("R3 enter", ra_active, 1'b1);
    probe("R3 rd inv", 4, m_r[4], 1'b1);
    // R4 poison spread, R6 inv address
    step(1, 2'd0, 16'h44, 6, 4, 5, 16'hBEEF, 0, 0, 0);
    probe("R4 chain", 6, 16'hBEEF, 1'b1);
    step(1, 2'd1, 16'h48, 7, 6, 0, 0, 0, 0, 0);
    probe("R6 dest inv", 7, m_r[7], 1'b1);
    // R7 collision: 0x200 has the same set index as 0x100
    step(1, 2'd1, 16'h4C, 0, 2, 0, 0, 0, 0, 0);
    // R9 nested miss
    step(1, 2'd1, 16'h50, 3, 5, 0, 0, 0, 0, 0);
    chk("R9 nested issue", qn, 2);
    // R5 store in runahead
    step(1, 2'd2, 16'h54, 0, 2, 3, 0, 0, 0, 0);
    // R8 poisoned branch
    step(1, 2'd3, 16'h58, 0, 6, 1, 0, 0, 0, 0);
    chk("R8 stall", fetch_stall, 1'b1);
    idle(0);
    // R10 exit on original fill
    idle(1);
    chk("R10 redirect", {redirect_valid, redirect_pc}, {1'b1, 16'h0040});
    step(1, 2'd0, 16'h0, 1, 0, 0, 16'hDEAD, 0, 0, 0);
    for (int i = 0; i < 8; i++) probe("R9 restored", i, snap[i], 1'b0);
    chk("R10 ignored", m_r[1], 16'h0100);
    while (qn > 0) idle(1);
    // R11 drain policy
    exit_drain = 1;
    step(1, 2'd1, 16'h80, 4, 1, 0, 0, 0, 0, 0);
    step(1, 2'd1, 16'h84, 6, 5, 0, 0, 0, 0, 0);
    idle(1);
    chk("R11 stays", ra_active, 1'b1);
    idle(1);
    chk("R11 exits", redirect_valid, 1'b1);
    idle(0);
    // R12 count limit
    exit_drain = 0;
    for (int i = 0; i < 8; i++) alu(i, 16'(i * 4));
    step(1, 2'd1, 16'hA0, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 1; i < 7; i++) step(1, 2'd1, 16'(16'hA0 + i), 7, i, 0, 0, 0, 0, 0);
    chk("R12 limit", qn, 6);
    while (qn > 0 || m_ra || m_rst) idle(1);
    // random, both policies
    for (int ph = 0; ph < 2; ph++) begin
      while (m_ra || m_rst) idle(qn > 0);
      exit_drain = ph[0];
      for (int n = 0; n < 4000; n++) begin
        logic [1:0] op;
        logic hit;
        op = 2'($urandom % 4);
        hit = m_ra ? ($urandom % 2 == 0) : ($urandom % 4 != 0);
        step($urandom % 8 != 0, op, 16'($urandom), int'($urandom % 8), int'($urandom % 8),
             int'($urandom % 8), 16'($urandom), hit, 16'($urandom), $urandom % 4 == 0);
      end
    end
    finish_run();
  end
endmodule